// File: doc/BRIEF.md
# Compare-and-Branch Pair Fusion Detector

This block sits on the instruction queue after instruction boundaries are marked and before decode. Each cycle it looks at a window of pre-decoded queue slots. Every slot carries a valid bit, an operation class, a 4-bit condition code, the kinds of its two operands, and the byte offsets within the fetch line where the instruction starts and ends. The block finds the pair of neighbouring slots, if any, where a flag-setting arithmetic or logic operation is directly followed by a conditional jump and the two may be merged into one compare-and-branch entry.

Only one merge happens per cycle, and it goes to the lowest-numbered pair that qualifies. Whether a pair qualifies depends on four things: the first opcode, the jump's condition group, the operand forms, and whether the pair crosses a line boundary. A mode input picks between a narrow legacy rule set and the full rule set. The result is registered. One cycle after a window is presented, `fuse_with_next[i]` marks the slot that absorbs its neighbour and `consumed[i+1]` marks the slot that was absorbed. A merged entry stays merged downstream.

Top module: `mf_fusion_detect`

## Requirements
- R1: Slots i and i+1 can fuse only if both are valid, slot i holds a flag-setting class (codes: 1 CMP, 2 TEST, 3 ADD, 4 SUB, 5 INC, 6 DEC, 7 AND) and slot i+1 holds the conditional-jump class (code 8). Code 0 (any other operation) never fuses.
- R2: In full mode (`mode_full`=1), the condition group is bits [3:1] of the condition code (0 overflow, 1 carry, 2 zero, 3 below-or-equal, 4 sign, 5 parity, 6 and 7 signed compare). TEST and AND fuse with every group. CMP, ADD and SUB fuse with groups 1, 2, 3, 6 and 7. INC and DEC fuse only with groups 2, 6 and 7.
- R3: In full mode, the first operand of the first instruction must be a register (kind 1). Its second source may be absent (0), a register (1), an immediate (2) or a memory operand (3), but not an instruction-pointer-relative memory operand (4).
- R4: A pair whose first instruction ends at the last byte of a line (offset LINE_BYTES-1) while the second starts at offset 0 never fuses.
- R5: At most one pair fuses per cycle, and it is the lowest-numbered eligible pair. A later eligible pair, or one that overlaps it, passes through unfused.
- R6: In legacy mode (`mode_full`=0), only CMP and TEST may fuse. TEST fuses with every group, while CMP fuses only with groups 1, 2 and 3 (carry and zero based).
- R7: In legacy mode, fusion is disabled when `cpu_mode` is 3 (64-bit) and allowed in modes 0, 1 and 2 (16-bit, 32-bit, compatibility). The operand forms register-register, register-immediate, register-memory and memory-register may fuse; memory-immediate may not.
- R8: Outputs are registered. They reflect the window one clock edge after it is presented. `consumed[i+1]` is set exactly when `fuse_with_next[i]` is set, and reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_full | input | 1 | 1 selects the full rule set, 0 the legacy rule set |
| cpu_mode | input | 2 | Operating mode: 0 16-bit, 1 32-bit, 2 compatibility, 3 64-bit |
| slot_valid | input | SLOTS | Per-slot valid bit |
| slot_opc | input | SLOTS*4 | Per-slot operation class |
| slot_cond | input | SLOTS*4 | Per-slot condition code |
| slot_opa | input | SLOTS*3 | Per-slot first operand kind |
| slot_opb | input | SLOTS*3 | Per-slot second source kind |
| slot_start | input | SLOTS*OFS_W | Per-slot start byte offset in the line |
| slot_end | input | SLOTS*OFS_W | Per-slot end byte offset in the line |
| fuse_with_next | output | SLOTS-1 | Bit i: slot i absorbs slot i+1 |
| consumed | output | SLOTS | Bit i: slot i was absorbed into slot i-1 |

## Verification
A table of single-pair windows walks every opcode against several condition groups in both modes. It also covers every operand form and the 64-bit mode gate, so each cell of the fusibility matrix that differs between opcodes, or between modes, is told apart from its neighbours. Multi-pair windows check the priority and overlap rules: two eligible pairs, a chained jump, a first pair blocked only by the line split, and a pair that starts at slot 1. These show that the earliest legal pair wins and that a blocked pair hands priority on. The line-split case is also paired with a control that differs only in offsets, which isolates the boundary check.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [3:0] {
    OPC_OTHER = 4'd0,
    OPC_CMP   = 4'd1,
    OPC_TEST  = 4'd2,
    OPC_ADD   = 4'd3,
    OPC_SUB   = 4'd4,
    OPC_INC   = 4'd5,
    OPC_DEC   = 4'd6,
    OPC_AND   = 4'd7,
    OPC_JCC   = 4'd8
  } opc_e;

  typedef enum logic [2:0] {
    OPK_NONE   = 3'd0,
    OPK_REG    = 3'd1,
    OPK_IMM    = 3'd2,
    OPK_MEM    = 3'd3,
    OPK_RIPMEM = 3'd4
  } opk_e;

  typedef enum logic [1:0] {
    CPU_16     = 2'd0,
    CPU_32     = 2'd1,
    CPU_COMPAT = 2'd2,
    CPU_64     = 2'd3
  } cpu_e;

  localparam logic [2:0] GRP_OVF   = 3'd0;
  localparam logic [2:0] GRP_CARRY = 3'd1;
  localparam logic [2:0] GRP_ZERO  = 3'd2;
  localparam logic [2:0] GRP_BE    = 3'd3;
  localparam logic [2:0] GRP_SLT   = 3'd6;
  localparam logic [2:0] GRP_SLE   = 3'd7;

  typedef struct packed {
    logic       valid;
    opc_e       opc;
    logic [3:0] cond;
    opk_e       opa;
    opk_e       opb;
  } slot_t;

  // Full rule set: opcode against condition group.
  function automatic logic cond_ok_full(opc_e op, logic [2:0] grp);
    case (op)
      OPC_TEST, OPC_AND: return 1'b1;
      OPC_CMP, OPC_ADD, OPC_SUB:
        return (grp == GRP_CARRY) || (grp == GRP_ZERO) || (grp == GRP_BE) ||
               (grp == GRP_SLT) || (grp == GRP_SLE);
      OPC_INC, OPC_DEC:
        return (grp == GRP_ZERO) || (grp == GRP_SLT) || (grp == GRP_SLE);
      default: return 1'b0;
    endcase
  endfunction

  // Legacy rule set: only the two compare-style opcodes.
  function automatic logic cond_ok_legacy(opc_e op, logic [2:0] grp);
    case (op)
      OPC_TEST: return 1'b1;
      OPC_CMP:  return (grp == GRP_CARRY) || (grp == GRP_ZERO) || (grp == GRP_BE);
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic opnd_ok_full(opk_e a, opk_e b);
    return (a == OPK_REG) && (b != OPK_RIPMEM);
  endfunction

  function automatic logic opnd_ok_legacy(opk_e a, opk_e b);
    logic a_mem;
    a_mem = (a == OPK_MEM) || (a == OPK_RIPMEM);
    return ((a == OPK_REG) && (b != OPK_NONE)) || (a_mem && (b == OPK_REG));
  endfunction

endpackage

// File: rtl/mf_pair_rules.sv
module mf_pair_rules
  import mf_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  localparam int OFS_W = $clog2(LINE_BYTES)
) (
  input  slot_t            first,
  input  slot_t            second,
  input  logic [OFS_W-1:0] first_end,
  input  logic [OFS_W-1:0] second_start,
  input  logic             mode_full,
  input  cpu_e             cpu,
  output logic             eligible,
  output logic             line_split
);

  localparam logic [OFS_W-1:0] LAST_BYTE = OFS_W'(LINE_BYTES - 1);

  logic [2:0] grp;
  logic       shape_ok;
  logic       full_ok;
  logic       legacy_ok;

  assign grp        = second.cond[3:1];
  assign line_split = (first_end == LAST_BYTE) && (second_start == '0);
  assign shape_ok   = first.valid && second.valid && (second.opc == OPC_JCC);
  assign full_ok    = cond_ok_full(first.opc, grp) && opnd_ok_full(first.opa, first.opb);
  assign legacy_ok  = (cpu != CPU_64) && cond_ok_legacy(first.opc, grp) &&
                      opnd_ok_legacy(first.opa, first.opb);

  assign eligible = shape_ok && !line_split && (mode_full ? full_ok : legacy_ok);

endmodule

// File: rtl/mf_first_pick.sv
module mf_first_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    grant = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) grant = N'(1) << k;
    end
  end

  // R5: the grant is one of the requests and no lower request exists.
  always_comb begin
    if (!$isunknown(req)) begin
      a_r5_grant_earliest: assert (((grant & ~req) == '0) &&
                                   ((req & (grant - N'(1))) == '0) &&
                                   ((req == '0) == (grant == '0)))
        else $error("R5 grant is not the earliest request");
    end
  end

endmodule

// File: rtl/mf_fusion_detect.sv
module mf_fusion_detect
  import mf_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int LINE_BYTES = 64,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int PAIRS  = SLOTS - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_full,
  input  logic [1:0]             cpu_mode,
  input  logic [SLOTS-1:0]       slot_valid,
  input  logic [SLOTS*4-1:0]     slot_opc,
  input  logic [SLOTS*4-1:0]     slot_cond,
  input  logic [SLOTS*3-1:0]     slot_opa,
  input  logic [SLOTS*3-1:0]     slot_opb,
  input  logic [SLOTS*OFS_W-1:0] slot_start,
  input  logic [SLOTS*OFS_W-1:0] slot_end,
  output logic [PAIRS-1:0]       fuse_with_next,
  output logic [SLOTS-1:0]       consumed
);

  slot_t            slots    [SLOTS];
  logic [OFS_W-1:0] s_start  [SLOTS];
  logic [OFS_W-1:0] s_end    [SLOTS];
  logic [PAIRS-1:0] pair_ok;
  logic [PAIRS-1:0] pair_split;
  logic [PAIRS-1:0] pick;
  cpu_e             cpu;

  assign cpu = cpu_e'(cpu_mode);

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign slots[s].valid = slot_valid[s];
    assign slots[s].opc   = opc_e'(slot_opc[s*4 +: 4]);
    assign slots[s].cond  = slot_cond[s*4 +: 4];
    assign slots[s].opa   = opk_e'(slot_opa[s*3 +: 3]);
    assign slots[s].opb   = opk_e'(slot_opb[s*3 +: 3]);
    assign s_start[s]     = slot_start[s*OFS_W +: OFS_W];
    assign s_end[s]       = slot_end[s*OFS_W +: OFS_W];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    mf_pair_rules #(.LINE_BYTES(LINE_BYTES)) u_rules (
      .first       (slots[p]),
      .second      (slots[p+1]),
      .first_end   (s_end[p]),
      .second_start(s_start[p+1]),
      .mode_full   (mode_full),
      .cpu         (cpu),
      .eligible    (pair_ok[p]),
      .line_split  (pair_split[p])
    );
  end

  mf_first_pick #(.N(PAIRS)) u_pick (
    .req  (pair_ok),
    .grant(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_with_next <= '0;
      consumed       <= '0;
    end else begin
      fuse_with_next <= pick;
      consumed       <= {pick, 1'b0};
    end
  end

  // R5: never more than one merge per cycle.
  a_r5_single_fusion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fuse_with_next))
    else $error("R5 more than one pair fused");

  // R7: legacy rules in 64-bit mode produce no merge.
  a_r7_legacy_64_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_full && cpu_mode == 2'd3) |=> (fuse_with_next == '0))
    else $error("R7 fusion in legacy 64-bit mode");

  // R8: slot 0 is never an absorbed slot.
  a_r8_slot0_never_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    !consumed[0])
    else $error("R8 slot 0 marked consumed");

  for (genvar p = 0; p < PAIRS; p++) begin : g_chk
    // R1: a merge needs two valid slots, the second a conditional jump.
    a_r1_pair_shape: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_with_next[p] |-> $past(slot_valid[p] && slot_valid[p+1] &&
                                  slot_opc[(p+1)*4 +: 4] == 4'd8 &&
                                  slot_opc[p*4 +: 4] != 4'd0))
      else $error("R1 illegal pair shape fused");

    // R4: a pair split across a line boundary is not merged.
    a_r4_no_line_split: assert property (@(posedge clk) disable iff (!rst_n)
      pair_split[p] |=> !fuse_with_next[p])
      else $error("R4 pair across line boundary fused");

    // R8: the absorbed neighbour is flagged together with its absorber.
    a_r8_consume_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_with_next[p] |-> (consumed[p+1] && !consumed[p]))
      else $error("R8 consumed flag out of step");
  end

endmodule

// File: tb/tb_mf_fusion_detect.sv
`timescale 1ns/1ps
module tb_mf_fusion_detect;

  localparam int SLOTS = 4;
  localparam int LINE_BYTES = 64;
  localparam int OFS_W = 6;
  localparam int PAIRS = SLOTS - 1;
  localparam int NVEC = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_full = 1'b1;
  logic [1:0] cpu_mode = 2'd1;
  logic [SLOTS-1:0] slot_valid = '0;
  logic [SLOTS*4-1:0] slot_opc = '0;
  logic [SLOTS*4-1:0] slot_cond = '0;
  logic [SLOTS*3-1:0] slot_opa = '0;
  logic [SLOTS*3-1:0] slot_opb = '0;
  logic [SLOTS*OFS_W-1:0] slot_start = '0;
  logic [SLOTS*OFS_W-1:0] slot_end = '0;
  logic [PAIRS-1:0] fuse_with_next;
  logic [SLOTS-1:0] consumed;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mf_fusion_detect #(.SLOTS(SLOTS), .LINE_BYTES(LINE_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .cpu_mode(cpu_mode),
    .slot_valid(slot_valid), .slot_opc(slot_opc), .slot_cond(slot_cond),
    .slot_opa(slot_opa), .slot_opb(slot_opb), .slot_start(slot_start),
    .slot_end(slot_end), .fuse_with_next(fuse_with_next), .consumed(consumed)
  );

  // {full, cpu, first opc, jump cond, opa, opb, expected fuse}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 2'd3, 4'd1, 4'h4, 3'd1, 3'd2, 1'b1},  // R2 cmp zero
    {1'b1, 2'd3, 4'd1, 4'h0, 3'd1, 3'd2, 1'b0},  // R2 cmp overflow
    {1'b1, 2'd3, 4'd1, 4'h8, 3'd1, 3'd2, 1'b0},  // R2 cmp sign
    {1'b1, 2'd3, 4'd1, 4'hC, 3'd1, 3'd2, 1'b1},  // R2 cmp signed
    {1'b1, 2'd3, 4'd3, 4'h2, 3'd1, 3'd1, 1'b1},  // R2 add carry
    {1'b1, 2'd3, 4'd4, 4'h7, 3'd1, 3'd2, 1'b1},  // R2 sub be
    {1'b1, 2'd3, 4'd4, 4'hA, 3'd1, 3'd2, 1'b0},  // R2 sub parity
    {1'b1, 2'd3, 4'd5, 4'h5, 3'd1, 3'd0, 1'b1},  // R2 inc zero
    {1'b1, 2'd3, 4'd5, 4'h2, 3'd1, 3'd0, 1'b0},  // R2 inc carry
    {1'b1, 2'd3, 4'd6, 4'h6, 3'd1, 3'd0, 1'b0},  // R2 dec be
    {1'b1, 2'd3, 4'd6, 4'hF, 3'd1, 3'd0, 1'b1},  // R2 dec signed
    {1'b1, 2'd3, 4'd2, 4'h0, 3'd1, 3'd1, 1'b1},  // R2 test overflow
    {1'b1, 2'd3, 4'd7, 4'h9, 3'd1, 3'd2, 1'b1},  // R2 and sign
    {1'b1, 2'd3, 4'd0, 4'h4, 3'd1, 3'd2, 1'b0},  // R1 other opcode
    {1'b1, 2'd3, 4'd1, 4'h4, 3'd1, 3'd4, 1'b0},  // R3 ip-relative
    {1'b1, 2'd3, 4'd1, 4'h4, 3'd3, 3'd1, 1'b0},  // R3 memory first
    {1'b1, 2'd3, 4'd1, 4'h4, 3'd1, 3'd3, 1'b1},  // R3 reg-mem
    {1'b1, 2'd0, 4'd2, 4'hB, 3'd1, 3'd0, 1'b1},  // R3 no second source
    {1'b0, 2'd1, 4'd1, 4'h2, 3'd1, 3'd1, 1'b1},  // R6 legacy cmp carry
    {1'b0, 2'd1, 4'd1, 4'h6, 3'd1, 3'd1, 1'b1},  // R6 legacy cmp be
    {1'b0, 2'd1, 4'd1, 4'hC, 3'd1, 3'd1, 1'b0},  // R6 legacy cmp signed
    {1'b0, 2'd1, 4'd3, 4'h4, 3'd1, 3'd1, 1'b0},  // R6 legacy add
    {1'b0, 2'd1, 4'd2, 4'h8, 3'd1, 3'd2, 1'b1},  // R6 legacy test sign
    {1'b0, 2'd0, 4'd1, 4'h4, 3'd3, 3'd2, 1'b0},  // R7 mem-imm
    {1'b0, 2'd0, 4'd1, 4'h4, 3'd3, 3'd1, 1'b1},  // R7 mem-reg
    {1'b0, 2'd3, 4'd2, 4'h4, 3'd1, 3'd2, 1'b0},  // R7 64-bit off
    {1'b0, 2'd2, 4'd2, 4'h4, 3'd1, 3'd2, 1'b1},  // R7 compat on
    {1'b0, 2'd1, 4'd5, 4'h4, 3'd1, 3'd0, 1'b0}   // R6 legacy inc
  };

  task automatic clear_slots();
    slot_valid = '0; slot_opc = '0; slot_cond = '0;
    slot_opa = '0; slot_opb = '0; slot_start = '0; slot_end = '0;
  endtask

  task automatic put(input int i, input logic [3:0] op, input logic [3:0] cc,
                     input logic [2:0] a, input logic [2:0] b,
                     input logic [5:0] st, input logic [5:0] en);
    slot_valid[i] = 1'b1;
    slot_opc[i*4 +: 4] = op;
    slot_cond[i*4 +: 4] = cc;
    slot_opa[i*3 +: 3] = a;
    slot_opb[i*3 +: 3] = b;
    slot_start[i*OFS_W +: OFS_W] = st;
    slot_end[i*OFS_W +: OFS_W] = en;
  endtask

  task automatic check(input logic [PAIRS-1:0] ef, input logic [SLOTS-1:0] ec,
                       input string tag);
    n_cmp++;
    if (fuse_with_next !== ef || consumed !== ec) begin
      n_bad++;
      $display("FAIL %s: fuse=%b consumed=%b expected fuse=%b consumed=%b",
               tag, fuse_with_next, consumed, ef, ec);
    end
  endtask

  // Inputs change at a falling edge; the registered result is checked one
  // full cycle later, after the rising edge that captures it.
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd0, 6'd5);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd6, 6'd7);
    repeat (3) @(negedge clk);
    check(3'b000, 4'b0000, "R8 reset holds outputs low");
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [17:0] e;
      e = VEC[v];
      clear_slots();
      mode_full = e[17];
      cpu_mode  = e[16:15];
      put(0, e[14:11], 4'h0, e[6:4], e[3:1], 6'd0, 6'd5);
      put(1, 4'd8, e[10:7], 3'd0, 3'd0, 6'd6, 6'd7);
      settle();
      check({2'b00, e[0]}, {2'b00, e[0], 1'b0}, $sformatf("R1/R2/R3/R6/R7 vector %0d", v));
    end

    mode_full = 1'b1; cpu_mode = 2'd1;

    // R4: split at the line boundary, then the same pair inside the line.
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd58, 6'd63);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd0, 6'd1);
    settle();
    check(3'b000, 4'b0000, "R4 pair across line boundary");
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd52, 6'd57);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd58, 6'd59);
    settle();
    check(3'b001, 4'b0010, "R4 control pair inside line");

    // R5: two eligible pairs, only the earlier merges.
    clear_slots();
    put(0, 4'd2, 4'h4, 3'd1, 3'd1, 6'd0, 6'd2);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd3, 6'd4);
    put(2, 4'd3, 4'h4, 3'd1, 3'd2, 6'd5, 6'd8);
    put(3, 4'd8, 4'h5, 3'd0, 3'd0, 6'd9, 6'd10);
    settle();
    check(3'b001, 4'b0010, "R5 two pairs earliest wins");

    // R5: blocked first pair hands priority on to the third pair.
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd60, 6'd63);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd0, 6'd1);
    put(2, 4'd1, 4'h4, 3'd1, 3'd2, 6'd2, 6'd5);
    put(3, 4'd8, 4'h4, 3'd0, 3'd0, 6'd6, 6'd7);
    settle();
    check(3'b100, 4'b1000, "R5 R4 blocked pair passes priority");

    // R5: pair starting at slot 1.
    clear_slots();
    put(0, 4'd0, 4'h0, 3'd1, 3'd1, 6'd0, 6'd2);
    put(1, 4'd4, 4'h2, 3'd1, 3'd2, 6'd3, 6'd6);
    put(2, 4'd8, 4'h2, 3'd0, 3'd0, 6'd7, 6'd8);
    settle();
    check(3'b010, 4'b0100, "R5 pair at slot 1");

    // R1: invalid jump slot blocks fusion.
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd0, 6'd5);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd6, 6'd7);
    slot_valid[1] = 1'b0;
    settle();
    check(3'b000, 4'b0000, "R1 invalid jump slot");

    // R1: two flag-setting ops then a jump fuse at the adjacent pair only.
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd0, 6'd5);
    put(1, 4'd1, 4'h4, 3'd1, 3'd2, 6'd6, 6'd9);
    put(2, 4'd8, 4'h4, 3'd0, 3'd0, 6'd10, 6'd11);
    settle();
    check(3'b010, 4'b0100, "R1 adjacency");

    // R8: reset while a fusable window is present clears outputs.
    clear_slots();
    put(0, 4'd1, 4'h4, 3'd1, 3'd2, 6'd0, 6'd5);
    put(1, 4'd8, 4'h4, 3'd0, 3'd0, 6'd6, 6'd7);
    settle();
    check(3'b001, 4'b0010, "R8 registered result");
    rst_n = 1'b0;
    #1;
    check(3'b000, 4'b0000, "R8 asynchronous reset clears");
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check(3'b001, 4'b0010, "R8 resumes after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule